// File: doc/BRIEF.md
# Single-Step Rotate and Shift Unit

This block moves an N-bit operand by one bit position, left or right. It serves the bit-manipulation instructions of a small accumulator processor. It covers four rotates, of which two are circular and two pass through the carry flag, two arithmetic shifts, a logical right shift and a pass-through code. An operation select picks the operation and a form bit picks the instruction variant. The block returns the moved value together with the zero, subtract, half-carry and carry flags.

The short accumulator form of a rotate always reports zero as clear. The extended form derives zero from the moved value. Carry always comes from the bit that leaves the original operand, and zero is always judged on the value that is produced, never on the operand. Results are captured on an input strobe and appear one clock later. They hold their value until the next strobe.

Top module: `rsu_top`

## Requirements
- R1: Code 0 (circular left) gives `{operand[N-2:0], operand[N-1]}`, and carry takes the old top bit. For example, 0x80 gives 0x01 with carry 1, and 0x02 gives 0x04 with carry 0.
- R2: Code 1 (circular right) gives `{operand[0], operand[N-1:1]}`, and carry takes the old bit 0. For example, 0x01 gives 0x80 with carry 1, and 0x40 gives 0x20 with carry 0.
- R3: Code 2 (left through carry) gives `{operand[N-2:0], carryIn}`, and carry takes the old top bit.
- R4: Code 3 (right through carry) gives `{carryIn, operand[N-1:1]}`, and carry takes the old bit 0.
- R5: Code 4 (arithmetic left) fills bit 0 with 0, and carry takes the old top bit. For example, 0x01 gives 0x02 with all flags clear, even with carryIn set.
- R6: Code 5 (arithmetic right) keeps the top bit, and carry takes the old bit 0. For example, 0x01 gives 0x00 with zero and carry both set.
- R7: Code 6 (logical right) fills the top bit with 0, and carry takes the old bit 0.
- R8: Code 7 passes the operand through unchanged, and carry equals carryIn.
- R9: When `extForm` is 0 and the code is 0 to 3, the zero flag is 0 whatever the result.
- R10: In every other case, the zero flag is 1 exactly when the produced result is all zeros. It is never judged on the operand.
- R11: The subtract and half-carry flags are always 0.
- R12: A strobe on `inValid` produces `outValid` and the new outputs one clock later. Without a strobe, `outValid` is 0 and the result and flags hold their values.
- R13: During reset, `outValid`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Capture strobe for the operation |
| opSel | input | 3 | Operation code (0 to 7, see R1 to R8) |
| extForm | input | 1 | 1 selects the extended form, 0 the accumulator form |
| operand | input | DW | Value to be moved |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| result | output | DW | Moved value |
| flagZero | output | 1 | Zero flag |
| flagSub | output | 1 | Subtract flag |
| flagHalf | output | 1 | Half-carry flag |
| flagCarry | output | 1 | Carry flag |

## Verification
The bench builds the unit with the default width of 8 bits. At that width the whole input space is small: 256 operands, two carry-in values, eight codes and two forms. The bench therefore sweeps all of it against an independent model, and every fill source, carry source and zero rule is exercised on every operand. The edge operands 0x00, 0x01, 0x80 and 0xFF fall inside that sweep. The stated example pairs and the hold behaviour between strobes are also checked separately.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef enum logic [2:0] {
    OP_ROL  = 3'd0,
    OP_ROR  = 3'd1,
    OP_RLT  = 3'd2,
    OP_RRT  = 3'd3,
    OP_SLA  = 3'd4,
    OP_SRA  = 3'd5,
    OP_SRL  = 3'd6,
    OP_PASS = 3'd7
  } rsuOpE;

  // Source of the bit entering the vacated position
  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_WRAP  = 2'd1,
    FILL_CARRY = 2'd2,
    FILL_SIGN  = 2'd3
  } fillE;

  typedef struct packed {
    logic capture;
    logic moveLeft;
    logic passThru;
    fillE fill;
    logic zeroForce;
  } rsuCtrlS;

endpackage

// File: rtl/rsu_ctrl.sv
module rsu_ctrl
  import rsu_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] opSel,
  input  logic       extForm,
  output rsuCtrlS    ctrl
);

  logic isRotate;

  always_comb begin
    ctrl           = '0;
    ctrl.capture   = inValid;
    isRotate       = 1'b0;
    unique case (rsuOpE'(opSel))
      OP_ROL:  begin ctrl.moveLeft = 1'b1; ctrl.fill = FILL_WRAP;  isRotate = 1'b1; end
      OP_ROR:  begin ctrl.moveLeft = 1'b0; ctrl.fill = FILL_WRAP;  isRotate = 1'b1; end
      OP_RLT:  begin ctrl.moveLeft = 1'b1; ctrl.fill = FILL_CARRY; isRotate = 1'b1; end
      OP_RRT:  begin ctrl.moveLeft = 1'b0; ctrl.fill = FILL_CARRY; isRotate = 1'b1; end
      OP_SLA:  begin ctrl.moveLeft = 1'b1; ctrl.fill = FILL_ZERO; end
      OP_SRA:  begin ctrl.moveLeft = 1'b0; ctrl.fill = FILL_SIGN; end
      OP_SRL:  begin ctrl.moveLeft = 1'b0; ctrl.fill = FILL_ZERO; end
      default: begin ctrl.passThru = 1'b1; end
    endcase
    // Short accumulator rotates report zero as clear
    ctrl.zeroForce = isRotate && !extForm;
  end

endmodule

// File: rtl/rsu_datapath.sv
module rsu_datapath
  import rsu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  rsuCtrlS       ctrl,
  input  logic [DW-1:0] operand,
  input  logic          carryIn,
  output logic          outValid,
  output logic [DW-1:0] result,
  output logic          flagZero,
  output logic          flagSub,
  output logic          flagHalf,
  output logic          flagCarry
);

  localparam int TOP = DW - 1;

  logic          exitBit;
  logic          fillBit;
  logic [DW-1:0] movedVal;
  logic [DW-1:0] nextRes;
  logic          nextCarry;
  logic          nextZero;

  always_comb begin
    exitBit = ctrl.moveLeft ? operand[TOP] : operand[0];
    unique case (ctrl.fill)
      FILL_ZERO:  fillBit = 1'b0;
      FILL_WRAP:  fillBit = exitBit;
      FILL_CARRY: fillBit = carryIn;
      default:    fillBit = operand[TOP];
    endcase
    if (ctrl.moveLeft) movedVal = {operand[TOP-1:0], fillBit};
    else               movedVal = {fillBit, operand[TOP:1]};
    nextRes   = ctrl.passThru ? operand : movedVal;
    nextCarry = ctrl.passThru ? carryIn : exitBit;
    nextZero  = !ctrl.zeroForce && (nextRes == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      flagZero  <= 1'b0;
      flagCarry <= 1'b0;
    end else begin
      outValid <= ctrl.capture;
      if (ctrl.capture) begin
        result    <= nextRes;
        flagZero  <= nextZero;
        flagCarry <= nextCarry;
      end
    end
  end

  assign flagSub  = 1'b0;
  assign flagHalf = 1'b0;

endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [2:0]    opSel,
  input  logic          extForm,
  input  logic [DW-1:0] operand,
  input  logic          carryIn,
  output logic          outValid,
  output logic [DW-1:0] result,
  output logic          flagZero,
  output logic          flagSub,
  output logic          flagHalf,
  output logic          flagCarry
);

  rsuCtrlS ctrl;

  rsu_ctrl u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .extForm (extForm),
    .ctrl    (ctrl)
  );

  rsu_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .operand   (operand),
    .carryIn   (carryIn),
    .outValid  (outValid),
    .result    (result),
    .flagZero  (flagZero),
    .flagSub   (flagSub),
    .flagHalf  (flagHalf),
    .flagCarry (flagCarry)
  );

endmodule

// File: rtl/rsu_chk.sv
module rsu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [2:0]    opSel,
  input logic          extForm,
  input logic [DW-1:0] operand,
  input logic          carryIn,
  input logic          outValid,
  input logic [DW-1:0] result,
  input logic          flagZero,
  input logic          flagSub,
  input logic          flagHalf,
  input logic          flagCarry
);

  p_rol_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd0) |=> (result[0] == flagCarry && flagCarry == $past(operand[DW-1])));

  p_ror_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd1) |=> (result[DW-1] == flagCarry && flagCarry == $past(operand[0])));

  p_sla_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd4) |=> (flagCarry == $past(operand[DW-1]) && !result[0]));

  p_sra_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd5) |=> (result[DW-1] == $past(operand[DW-1])));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd7) |=> (result == $past(operand) && flagCarry == $past(carryIn)));

  p_zero_forced_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !extForm && opSel < 3'd4) |=> !flagZero);

  p_zero_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (extForm || opSel >= 3'd4)) |=> (flagZero == (result == '0)));

  p_sub_half_r11: assert property (@(posedge clk) disable iff (!rstN)
    !flagSub && !flagHalf);

  p_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(flagCarry) && $stable(flagZero)));

endmodule

bind rsu_top rsu_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .extForm   (extForm),
  .operand   (operand),
  .carryIn   (carryIn),
  .outValid  (outValid),
  .result    (result),
  .flagZero  (flagZero),
  .flagSub   (flagSub),
  .flagHalf  (flagHalf),
  .flagCarry (flagCarry)
);

// File: tb/rsu_top_tb.sv
`timescale 1ns/1ps
module rsu_top_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [2:0]    opSel = '0;
  logic          extForm = 1'b0;
  logic [DW-1:0] operand = '0;
  logic          carryIn = 1'b0;
  logic          outValid;
  logic [DW-1:0] result;
  logic          flagZero, flagSub, flagHalf, flagCarry;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rsu_top #(.DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .extForm(extForm),
    .operand(operand), .carryIn(carryIn), .outValid(outValid), .result(result),
    .flagZero(flagZero), .flagSub(flagSub), .flagHalf(flagHalf), .flagCarry(flagCarry)
  );

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Independent reference: returns {zero, carry, result}
  function automatic logic [DW+1:0] model(input logic [2:0] op, input logic ext,
                                          input logic [DW-1:0] v, input logic cin);
    logic [DW-1:0] r;
    logic c;
    logic z;
    case (op)
      3'd0: begin r = (v << 1) | (v >> (DW-1)); c = v[DW-1]; end
      3'd1: begin r = (v >> 1) | (v << (DW-1)); c = v[0]; end
      3'd2: begin r = (v << 1) | DW'(cin); c = v[DW-1]; end
      3'd3: begin r = (v >> 1) | (DW'(cin) << (DW-1)); c = v[0]; end
      3'd4: begin r = v << 1; c = v[DW-1]; end
      3'd5: begin r = (v >> 1) | (v & (DW'(1) << (DW-1))); c = v[0]; end
      3'd6: begin r = v >> 1; c = v[0]; end
      default: begin r = v; c = cin; end
    endcase
    if (!ext && op < 3'd4) z = 1'b0;
    else z = (r == 0);
    return {z, c, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Apply one strobe and check outputs one cycle later
  task automatic apply(input logic [2:0] op, input logic ext, input logic [DW-1:0] v,
                       input logic cin);
    logic [DW+1:0] e;
    e = model(op, ext, v, cin);
    opSel = op; extForm = ext; operand = v; carryIn = cin; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check({opTag(op), " result"}, 32'(result), 32'(e[DW-1:0]));
    check({opTag(op), " carry"}, 32'(flagCarry), 32'(e[DW]));
    check((!ext && op < 3'd4) ? "R9 zero forced" : "R10 zero from result",
          32'(flagZero), 32'(e[DW+1]));
    check("R11 sub/half", 32'({flagSub, flagHalf}), 32'(0));
    check("R12 outValid", 32'(outValid), 32'(1));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R13 reset outValid", 32'(outValid), 32'(0));
    check("R13 reset result", 32'(result), 32'(0));
    check("R13 reset flags", 32'({flagZero, flagSub, flagHalf, flagCarry}), 32'(0));
  endtask

  task automatic test_examples();
    apply(3'd0, 1'b1, 8'h80, 1'b0);  // R1 -> 0x01 C=1
    check("R1 example 0x80", 32'({flagCarry, result}), 32'(9'h101));
    apply(3'd0, 1'b1, 8'h02, 1'b0);  // R1 -> 0x04 C=0
    check("R1 example 0x02", 32'({flagCarry, result}), 32'(9'h004));
    apply(3'd1, 1'b1, 8'h01, 1'b0);  // R2 -> 0x80 C=1
    check("R2 example 0x01", 32'({flagCarry, result}), 32'(9'h180));
    apply(3'd1, 1'b1, 8'h40, 1'b0);  // R2 -> 0x20 C=0
    check("R2 example 0x40", 32'({flagCarry, result}), 32'(9'h020));
    apply(3'd4, 1'b1, 8'h01, 1'b1);  // R5 -> 0x02 all flags clear
    check("R5 example 0x01", 32'({flagZero, flagCarry, result}), 32'(10'h002));
    apply(3'd5, 1'b1, 8'h01, 1'b0);  // R6 -> 0x00 Z=1 C=1
    check("R6 example 0x01", 32'({flagZero, flagCarry, result}), 32'(10'h300));
    apply(3'd0, 1'b0, 8'h00, 1'b0);  // R9 zero result but flag forced clear
    check("R9 zero result accumulator form", 32'(flagZero), 32'(0));
  endtask

  task automatic test_sweep();
    for (int op = 0; op < 8; op++)
      for (int ext = 0; ext < 2; ext++)
        for (int cin = 0; cin < 2; cin++)
          for (int v = 0; v < 256; v++)
            apply(3'(op), 1'(ext), DW'(v), 1'(cin));
  endtask

  task automatic test_hold();
    logic [DW-1:0] keepRes;
    logic keepC, keepZ;
    apply(3'd6, 1'b1, 8'hA5, 1'b0);
    keepRes = result; keepC = flagCarry; keepZ = flagZero;
    opSel = 3'd4; operand = 8'h00; carryIn = 1'b1; extForm = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 no strobe outValid low", 32'(outValid), 32'(0));
    check("R12 no strobe result hold", 32'(result), 32'(keepRes));
    check("R12 no strobe flags hold", 32'({flagZero, flagCarry}), 32'({keepZ, keepC}));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rstN = 1'b1;
    test_examples();
    test_hold();
    test_sweep();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule